// File: doc/BRIEF.md
# Tearing-Effect Sync Discriminator

A display panel reports its refresh position on one tearing-effect wire. Horizontal and vertical sync pulses both travel on that wire and differ only in their length. This block synchronises the wire into the core clock and measures every active run in clock ticks. It sorts each run into a horizontal sync, a vertical sync or noise, using two programmed width thresholds. It counts horizontal syncs since the last vertical sync. It issues a one-cycle transfer trigger according to the selected trigger mode.

Software programs the thresholds, the two polarity bits, the trigger mode and the target line. A single load strobe captures all of them into shadow registers. The same load checks the values against the width rules and keeps an error flag that stays set until a later load with legal values. The transfer enable arms the trigger. Each period of the enable produces at most one trigger.

Top module: `te_sync_discriminator`

## Requirements
- R1: A run at the vertical-sync active level that lasts at least the VSYNC threshold is reported as a vertical sync (a one-cycle `vsync_seen` pulse after the run ends) and resets the line count to 0.
- R2: A run at the horizontal-sync active level that lasts at least the HSYNC threshold but less than the VSYNC threshold is reported on `hsync_seen` and adds one to the line count. A shorter run produces no report and leaves the line count unchanged. The two reports never occur in the same cycle.
- R3: A polarity bit set to 1 makes its sync active high. A polarity bit cleared to 0 makes it active low, so a low run on a high idle wire is measured.
- R4: Mode 0 (internal trigger) issues exactly one trigger when `xfer_en` rises and ignores the tearing-effect wire.
- R5: Mode 1 issues the trigger on the first vertical sync reported while `xfer_en` is high.
- R6: Mode 2 issues the trigger on the horizontal sync that brings the line count, counted from a vertical sync seen while enabled, to the 11-bit target (0 to 2047). A target of 0 triggers on the vertical sync itself.
- R7: A load sets the sticky `cfg_err` flag if the values break the rules. The rules are: mode 3 is reserved, and in modes 1 and 2 the HSYNC threshold must be at least 2, the VSYNC threshold must be at least 4 in mode 1 or at least 2 in mode 2, and the two thresholds must differ. No trigger is issued while the flag is set. A load with legal values clears the flag.
- R8: `trig` is a one-cycle pulse that only follows a cycle with `xfer_en` high. At most one trigger occurs per enable period, and dropping `xfer_en` clears the armed state.
- R9: After reset `trig`, `cfg_err`, `vsync_seen` and `hsync_seen` are low, and the shadow configuration is mode 0 with legal thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_in | input | 1 | Tearing-effect wire from the panel (asynchronous) |
| cfg_load | input | 1 | Captures all cfg_* inputs and validates them |
| cfg_hs_width | input | WW | HSYNC width threshold in ticks |
| cfg_vs_width | input | WW | VSYNC width threshold in ticks |
| cfg_hs_act_high | input | 1 | 1: HSYNC active high, 0: active low |
| cfg_vs_act_high | input | 1 | 1: VSYNC active high, 0: active low |
| cfg_mode | input | 2 | 0 internal, 1 on VSYNC, 2 on target line, 3 reserved |
| cfg_line | input | LW | Target line for mode 2 |
| xfer_en | input | 1 | Transfer enable |
| trig | output | 1 | One-cycle transfer trigger |
| cfg_err | output | 1 | Sticky configuration error |
| vsync_seen | output | 1 | Vertical sync recognised (one cycle) |
| hsync_seen | output | 1 | Horizontal sync recognised (one cycle) |

## Verification
The hardest case to reach from the ports is a short run that must leave the line count untouched. The count is not visible at the ports, so the bench shows it through the mode-2 trigger: it places a sub-threshold pulse between counted lines and expects the trigger exactly on the target line. A scoreboard holds the expected order of sync reports and triggers. Any extra report, including one from a short pulse, a trigger in mode 0 caused by the wire, or a trigger while the error flag is set, reaches the monitor with an empty queue and is flagged. The active-low case first moves the idle level of the wire with the monitor muted, then measures low pulses.

// File: rtl/tesd_pkg.sv
package tesd_pkg;
  typedef enum logic [1:0] {
    TRG_INTERNAL = 2'd0,
    TRG_ON_VSYNC = 2'd1,
    TRG_ON_LINE  = 2'd2,
    TRG_RESERVED = 2'd3
  } trg_mode_e;

  localparam int HS_MIN_TICKS      = 2;
  localparam int VS_MIN_TICKS_LINE = 2;
  localparam int VS_MIN_TICKS_VS   = 4;
endpackage

// File: rtl/tesd_cfg_check.sv
module tesd_cfg_check
  import tesd_pkg::*;
#(
  parameter int WW = 8,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [WW-1:0] hs_in,
  input  logic [WW-1:0] vs_in,
  input  logic          hs_high_in,
  input  logic          vs_high_in,
  input  logic [1:0]    mode_in,
  input  logic [LW-1:0] line_in,
  output logic [WW-1:0] hs_thr,
  output logic [WW-1:0] vs_thr,
  output logic          hs_high,
  output logic          vs_high,
  output trg_mode_e     mode,
  output logic [LW-1:0] line_tgt,
  output logic          err
);
  localparam logic [WW-1:0] HS_MIN = WW'(HS_MIN_TICKS);
  localparam logic [WW-1:0] VS_MIN_L = WW'(VS_MIN_TICKS_LINE);
  localparam logic [WW-1:0] VS_MIN_V = WW'(VS_MIN_TICKS_VS);

  logic          bad;
  logic [WW-1:0] vs_floor;
  logic [WW-1:0] hs_d, vs_d;
  logic          hsh_d, vsh_d, err_d;
  trg_mode_e     mode_d;
  logic [LW-1:0] line_d;

  // Legality of the values presented with a load strobe
  always_comb begin
    vs_floor = (mode_in == TRG_ON_VSYNC) ? VS_MIN_V : VS_MIN_L;
    if (mode_in == TRG_RESERVED) begin
      bad = 1'b1;
    end else if (mode_in == TRG_INTERNAL) begin
      bad = 1'b0;
    end else begin
      bad = (hs_in < HS_MIN) || (vs_in < vs_floor) || (hs_in == vs_in);
    end
  end

  always_comb begin
    hs_d   = hs_thr;
    vs_d   = vs_thr;
    hsh_d  = hs_high;
    vsh_d  = vs_high;
    mode_d = mode;
    line_d = line_tgt;
    err_d  = err;
    if (load) begin
      hs_d   = hs_in;
      vs_d   = vs_in;
      hsh_d  = hs_high_in;
      vsh_d  = vs_high_in;
      mode_d = trg_mode_e'(mode_in);
      line_d = line_in;
      err_d  = bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_thr   <= HS_MIN;
      vs_thr   <= VS_MIN_V;
      hs_high  <= 1'b1;
      vs_high  <= 1'b1;
      mode     <= TRG_INTERNAL;
      line_tgt <= '0;
      err      <= 1'b0;
    end else begin
      hs_thr   <= hs_d;
      vs_thr   <= vs_d;
      hs_high  <= hsh_d;
      vs_high  <= vsh_d;
      mode     <= mode_d;
      line_tgt <= line_d;
      err      <= err_d;
    end
  end
endmodule

// File: rtl/tesd_sync_meter.sv
module tesd_sync_meter #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          te_in,
  input  logic [WW-1:0] hs_thr,
  input  logic [WW-1:0] vs_thr,
  input  logic          hs_high,
  input  logic          vs_high,
  output logic          hs_evt,
  output logic          vs_evt
);
  localparam int NCH = 2;   // channel 0: HSYNC level, channel 1: VSYNC level
  localparam logic [WW-1:0] SAT = {WW{1'b1}};

  logic                    s_meta, s_pin;
  logic [NCH-1:0]          lvl_act;
  logic [NCH-1:0]          run_end;
  logic [NCH-1:0][WW-1:0]  run_len;
  logic                    hs_hit, vs_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_pin  <= 1'b0;
    end else begin
      s_meta <= te_in;
      s_pin  <= s_meta;
    end
  end

  assign lvl_act[0] = (s_pin == hs_high);
  assign lvl_act[1] = (s_pin == vs_high);

  // One saturating run-length counter per active level
  for (genvar g = 0; g < NCH; g++) begin : g_run
    logic [WW-1:0] cnt_q, cnt_d;
    always_comb begin
      if (!lvl_act[g])      cnt_d = '0;
      else if (cnt_q == SAT) cnt_d = cnt_q;
      else                  cnt_d = cnt_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end
    assign run_len[g] = cnt_q;
    assign run_end[g] = !lvl_act[g] && (cnt_q != '0);
  end

  assign vs_hit = run_end[1] && (run_len[1] >= vs_thr);
  assign hs_hit = run_end[0] && (run_len[0] >= hs_thr) && (run_len[0] < vs_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_evt <= 1'b0;
      vs_evt <= 1'b0;
    end else begin
      hs_evt <= hs_hit;
      vs_evt <= vs_hit;
    end
  end
endmodule

// File: rtl/tesd_line_trig.sv
module tesd_line_trig
  import tesd_pkg::*;
#(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_evt,
  input  logic          vs_evt,
  input  trg_mode_e     mode,
  input  logic [LW-1:0] line_tgt,
  input  logic          err,
  input  logic          en,
  output logic          trig
);
  localparam logic [LW-1:0] LINE_MAX = {LW{1'b1}};

  logic [LW-1:0] line_q, line_d;
  logic          armed_q, armed_d;
  logic          done_q, done_d;
  logic          en_q;
  logic          ok, fire, line_hit;

  always_comb begin
    line_d = line_q;
    if (vs_evt)                           line_d = '0;
    else if (hs_evt && line_q != LINE_MAX) line_d = line_q + 1'b1;
  end

  assign ok       = en && !done_q && !err;
  assign line_hit = ({1'b0, line_q} + 1'b1) == {1'b0, line_tgt};

  always_comb begin
    case (mode)
      TRG_INTERNAL: fire = ok && !en_q;
      TRG_ON_VSYNC: fire = ok && vs_evt;
      TRG_ON_LINE:  fire = ok && ((vs_evt && line_tgt == '0) ||
                                  (!vs_evt && hs_evt && armed_q && line_hit));
      default:      fire = 1'b0;
    endcase
  end

  always_comb begin
    armed_d = armed_q;
    done_d  = done_q;
    if (!en) begin
      armed_d = 1'b0;
      done_d  = 1'b0;
    end else begin
      if (vs_evt) armed_d = 1'b1;
      if (fire)   done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      en_q    <= 1'b0;
      trig    <= 1'b0;
    end else begin
      line_q  <= line_d;
      armed_q <= armed_d;
      done_q  <= done_d;
      en_q    <= en;
      trig    <= fire;
    end
  end
endmodule

// File: rtl/te_sync_discriminator.sv
module te_sync_discriminator
  import tesd_pkg::*;
#(
  parameter int WW = 8,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          te_in,
  input  logic          cfg_load,
  input  logic [WW-1:0] cfg_hs_width,
  input  logic [WW-1:0] cfg_vs_width,
  input  logic          cfg_hs_act_high,
  input  logic          cfg_vs_act_high,
  input  logic [1:0]    cfg_mode,
  input  logic [LW-1:0] cfg_line,
  input  logic          xfer_en,
  output logic          trig,
  output logic          cfg_err,
  output logic          vsync_seen,
  output logic          hsync_seen
);
  logic [1:0]    rst_pipe;
  logic          rst_core_n;
  logic [WW-1:0] hs_thr, vs_thr;
  logic          hs_high, vs_high;
  trg_mode_e     mode_q;
  logic [LW-1:0] line_tgt;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  tesd_cfg_check #(.WW(WW), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_core_n), .load(cfg_load),
    .hs_in(cfg_hs_width), .vs_in(cfg_vs_width),
    .hs_high_in(cfg_hs_act_high), .vs_high_in(cfg_vs_act_high),
    .mode_in(cfg_mode), .line_in(cfg_line),
    .hs_thr(hs_thr), .vs_thr(vs_thr), .hs_high(hs_high), .vs_high(vs_high),
    .mode(mode_q), .line_tgt(line_tgt), .err(cfg_err)
  );

  tesd_sync_meter #(.WW(WW)) u_meter (
    .clk(clk), .rst_n(rst_core_n), .te_in(te_in),
    .hs_thr(hs_thr), .vs_thr(vs_thr), .hs_high(hs_high), .vs_high(vs_high),
    .hs_evt(hsync_seen), .vs_evt(vsync_seen)
  );

  tesd_line_trig #(.LW(LW)) u_trig (
    .clk(clk), .rst_n(rst_core_n), .hs_evt(hsync_seen), .vs_evt(vsync_seen),
    .mode(mode_q), .line_tgt(line_tgt), .err(cfg_err), .en(xfer_en),
    .trig(trig)
  );
endmodule

// File: rtl/tesd_checker.sv
module tesd_checker
  import tesd_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      xfer_en,
  input logic      trig,
  input logic      cfg_err,
  input logic      vsync_seen,
  input logic      hsync_seen,
  input trg_mode_e mode_q
);
  assert_trig_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  assert_trig_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(xfer_en));

  assert_classes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vsync_seen, hsync_seen}));

  assert_no_trig_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err)) |-> !trig);

  assert_vsync_mode_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(mode_q) == TRG_ON_VSYNC) |-> $past(vsync_seen));

  assert_line_mode_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(mode_q) == TRG_ON_LINE) |-> $past(vsync_seen || hsync_seen));

  assert_internal_mode_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(mode_q) == TRG_INTERNAL) |-> $rose($past(xfer_en)));
endmodule

bind te_sync_discriminator tesd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .trig(trig), .cfg_err(cfg_err),
  .vsync_seen(vsync_seen), .hsync_seen(hsync_seen), .mode_q(mode_q)
);

// File: tb/sim_te_sync_discriminator.sv
module sim_te_sync_discriminator;
  localparam int CLK_P = 10;
  localparam int WW = 8;
  localparam int LW = 11;
  localparam int EV_VS = 1, EV_HS = 2, EV_TRIG = 3;

  typedef struct {
    int    kind;
    string req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          te_in;
  logic          cfg_load;
  logic [WW-1:0] cfg_hs_width, cfg_vs_width;
  logic          cfg_hs_act_high, cfg_vs_act_high;
  logic [1:0]    cfg_mode;
  logic [LW-1:0] cfg_line;
  logic          xfer_en;
  logic          trig, cfg_err, vsync_seen, hsync_seen;

  int    checks = 0, errors = 0;
  bit    quiet = 1'b0;
  bit    finished = 1'b0;
  string ctx = "R9";
  item_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  te_sync_discriminator #(.WW(WW), .LW(LW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input string req);
    item_t it;
    it.kind = kind;
    it.req  = req;
    sb.push_back(it);
  endtask

  task automatic pop_cmp(input int kind);
    item_t it;
    if (sb.size() == 0) begin
      chk(1'b0, ctx, "unexpected event", kind, 0);
    end else begin
      it = sb.pop_front();
      chk(it.kind == kind, it.req, "event kind", kind, it.kind);
    end
  endtask

  // Monitor: compare each output pulse with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && !quiet) begin
      if (vsync_seen) pop_cmp(EV_VS);
      if (hsync_seen) pop_cmp(EV_HS);
      if (trig)       pop_cmp(EV_TRIG);
    end
  end

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input int hs, input int vs, input bit hh, input bit vh,
                      input int mode, input int line);
    @(posedge clk); #1;
    cfg_hs_width = WW'(hs);  cfg_vs_width = WW'(vs);
    cfg_hs_act_high = hh;    cfg_vs_act_high = vh;
    cfg_mode = 2'(mode);     cfg_line = LW'(line);
    cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
    settle(2);
  endtask

  task automatic pulse(input int w, input bit act);
    @(posedge clk); #1;
    te_in = act;
    repeat (w) @(posedge clk);
    #1;
    te_in = !act;
    settle(8);
  endtask

  task automatic set_en(input bit v);
    @(posedge clk); #1;
    xfer_en = v;
    settle(4);
  endtask

  task automatic drained(input string req);
    settle(6);
    chk(sb.size() == 0, req, "scoreboard left over", sb.size(), 0);
  endtask

  initial begin
    #(CLK_P * 60000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; te_in = 1'b0; cfg_load = 1'b0; xfer_en = 1'b0;
    cfg_hs_width = '0; cfg_vs_width = '0; cfg_hs_act_high = 1'b1;
    cfg_vs_act_high = 1'b1; cfg_mode = 2'd0; cfg_line = '0;
    settle(4);
    rst_n = 1'b1;
    settle(4);
    // R9 reset state
    chk(trig == 1'b0,       "R9", "trig after reset", trig, 0);
    chk(cfg_err == 1'b0,    "R9", "cfg_err after reset", cfg_err, 0);
    chk(vsync_seen == 1'b0, "R9", "vsync_seen after reset", vsync_seen, 0);
    chk(hsync_seen == 1'b0, "R9", "hsync_seen after reset", hsync_seen, 0);

    // R1 / R2: classification, enable low so no trigger
    ctx = "R2";
    load(3, 8, 1, 1, 1, 0);
    chk(cfg_err == 1'b0, "R7", "legal mode 1 config", cfg_err, 0);
    pulse(2, 1'b1);                        // below HSYNC threshold: nothing
    push(EV_HS, "R2"); pulse(4, 1'b1);
    push(EV_HS, "R2"); pulse(7, 1'b1);     // one below VSYNC threshold
    push(EV_VS, "R1"); pulse(8, 1'b1);     // exactly the VSYNC threshold
    push(EV_VS, "R1"); pulse(12, 1'b1);
    drained("R2");

    // R5 / R8: mode 1 triggers once per enable
    ctx = "R5";
    set_en(1'b1);
    push(EV_VS, "R5"); push(EV_TRIG, "R5"); pulse(12, 1'b1);
    push(EV_VS, "R8"); pulse(12, 1'b1);    // second VSYNC: no second trigger
    set_en(1'b0);
    push(EV_VS, "R8"); pulse(12, 1'b1);    // disabled: no trigger
    drained("R8");

    // R4: internal trigger on enable rise, wire ignored
    ctx = "R4";
    load(3, 8, 1, 1, 0, 0);
    push(EV_TRIG, "R4");
    set_en(1'b1);
    push(EV_VS, "R4"); pulse(12, 1'b1);
    push(EV_HS, "R4"); pulse(4, 1'b1);
    set_en(1'b0);
    drained("R4");

    // R6: trigger on target line 3, short pulse not counted
    ctx = "R6";
    load(3, 8, 1, 1, 2, 3);
    set_en(1'b1);
    push(EV_HS, "R6"); pulse(4, 1'b1);     // before any VSYNC: not armed
    push(EV_VS, "R6"); pulse(12, 1'b1);
    push(EV_HS, "R6"); pulse(4, 1'b1);     // line 1
    push(EV_HS, "R6"); pulse(4, 1'b1);     // line 2
    pulse(2, 1'b1);                        // short: line stays 2
    push(EV_HS, "R6"); push(EV_TRIG, "R6"); pulse(4, 1'b1);  // line 3
    push(EV_HS, "R6"); pulse(4, 1'b1);
    set_en(1'b0);
    drained("R6");

    // R6: target 0 fires on the VSYNC itself
    load(3, 8, 1, 1, 2, 0);
    set_en(1'b1);
    push(EV_VS, "R6"); push(EV_TRIG, "R6"); pulse(12, 1'b1);
    push(EV_HS, "R6"); pulse(4, 1'b1);
    set_en(1'b0);
    drained("R6");

    // R7: rule checks at load
    ctx = "R7";
    load(1, 8, 1, 1, 1, 0);
    chk(cfg_err == 1'b1, "R7", "HSYNC below 2", cfg_err, 1);
    load(2, 3, 1, 1, 1, 0);
    chk(cfg_err == 1'b1, "R7", "VSYNC 3 in mode 1", cfg_err, 1);
    load(2, 3, 1, 1, 2, 0);
    chk(cfg_err == 1'b0, "R7", "VSYNC 3 in mode 2", cfg_err, 0);
    load(3, 8, 1, 1, 3, 0);
    chk(cfg_err == 1'b1, "R7", "reserved mode", cfg_err, 1);
    load(5, 5, 1, 1, 1, 0);
    chk(cfg_err == 1'b1, "R7", "equal widths", cfg_err, 1);
    set_en(1'b1);
    push(EV_VS, "R7"); pulse(12, 1'b1);    // error set: no trigger
    chk(cfg_err == 1'b1, "R7", "error is sticky", cfg_err, 1);
    load(3, 8, 1, 1, 1, 0);
    chk(cfg_err == 1'b0, "R7", "legal load clears error", cfg_err, 0);
    push(EV_VS, "R7"); push(EV_TRIG, "R7"); pulse(12, 1'b1);
    set_en(1'b0);
    drained("R7");

    // R3: active-low syncs on a high idle wire
    ctx = "R3";
    quiet = 1'b1;
    load(3, 8, 0, 0, 1, 0);
    @(posedge clk); #1;
    te_in = 1'b1;
    settle(20);
    quiet = 1'b0;
    push(EV_VS, "R3"); pulse(12, 1'b0);
    push(EV_HS, "R3"); pulse(4, 1'b0);
    pulse(2, 1'b0);
    set_en(1'b1);
    push(EV_VS, "R3"); push(EV_TRIG, "R3"); pulse(12, 1'b0);
    set_en(1'b0);
    drained("R3");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule